// File: doc/BRIEF.md
# Clamped Double-Buffered VCOM Code Register

This block keeps the 10-bit code for a panel common-electrode (VCOM) driver in two register layers. A bus controller writes the requested code into the first layer. A separate update pulse later copies it into the second layer, which drives the DAC. Between the two layers sits a limiter with a programmable upper bound and lower bound. Both bounds are held in their own registers, are written the same way as the code, and reset to values that leave every code untouched.

Because the requested code stays in the first layer, the bounds can be changed before or after the code is written. The limiter is evaluated again on the next update pulse. The first-layer value, before any limiting, is offered on a separate port for a non-volatile store. The limited value is the one that reaches the DAC and the one that is read back. In addition, the DAC code never exceeds 960, whatever the bounds are.

Top module: `vcom_clamp_reg`

## Requirements
- R1: After reset the DAC code and the requested code are both 0x200, the upper bound is 0x3FF and the lower bound is 0x000.
- R2: A write with `wr_addr` = 0x12 loads `wr_data` into the requested code on the next clock edge. It leaves `dac_code` unchanged until an update pulse.
- R3: `dac_code` changes only on the clock edge that samples `upd_en` high. On that edge it takes the limited value of the requested code.
- R4: When the upper bound is not below the lower bound and the requested code is above the upper bound, the update latches the upper bound.
- R5: When the upper bound is not below the lower bound and the requested code is below the lower bound, the update latches the lower bound.
- R6: When the upper bound is below the lower bound, both bounds are ignored and the update latches the requested code.
- R7: A requested code that lies between the bounds, inclusive, is latched unchanged.
- R8: Writes to the bounds (0x1E upper, 0x1F lower) do not change `dac_code`. The next update limits the retained requested code with the new bounds.
- R9: `nvm_data` always shows the requested code as written, before limiting, and changes only on a write to 0x12.
- R10: `dac_code` never exceeds 960. A larger limited value is latched as 960.
- R11: `rd_data` returns the latched DAC code for address 0x12, the upper bound for 0x1E, the lower bound for 0x1F, and 0 for any other address.
- R12: When a write and an update fall in the same cycle, the update uses the value being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write target: 0x12 code, 0x1E upper bound, 0x1F lower bound |
| wr_data | input | 10 | Write value |
| upd_en | input | 1 | Update pulse: load the second layer through the limiter |
| rd_addr | input | 6 | Readback address |
| rd_data | output | 10 | Readback value (combinational) |
| dac_code | output | 10 | Second-layer code driving the DAC |
| nvm_data | output | 10 | Requested code before limiting, for the non-volatile store |

## Verification
A wrong requested code or a wrong bound stays hidden until the next update pulse. One clock later it shows as a wrong `dac_code` and a wrong readback at 0x12. A wrong requested code also shows on `nvm_data` on the cycle after the write. A wrong bound shows at once on the combinational readback of 0x1E or 0x1F. The bench therefore checks each update one cycle after the pulse. It puts the bounds in each ordering, including equal and inverted bounds, and drives the code above, below and between them. It reads the bounds back directly, so a corrupted bound is caught before it can affect the DAC.

// File: rtl/vcom_pkg.sv
package vcom_pkg;
  localparam int unsigned CODE_W = 10;
  localparam int unsigned PTR_W  = 6;

  // Register selectors on the write and read paths
  typedef enum logic [PTR_W-1:0] {
    SEL_VCOM   = 6'h12,
    SEL_LIM_HI = 6'h1E,
    SEL_LIM_LO = 6'h1F
  } sel_e;

  typedef struct packed {
    logic lo;
    logic hi;
    logic vcom;
  } wsel_t;
endpackage

// File: rtl/vcom_wr_decode.sv
module vcom_wr_decode
  import vcom_pkg::*;
(
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  output wsel_t            sel
);
  always_comb begin
    sel      = '0;
    sel.vcom = wr_en && (wr_addr == SEL_VCOM);
    sel.hi   = wr_en && (wr_addr == SEL_LIM_HI);
    sel.lo   = wr_en && (wr_addr == SEL_LIM_LO);
  end
endmodule

// File: rtl/vcom_stage1.sv
// First layer: requested code plus the two bound registers.
// Slot 0 = code, 1 = upper bound, 2 = lower bound.
module vcom_stage1 #(
  parameter int unsigned W      = 10,
  parameter int unsigned RST_IN = 'h200
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] in_q,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] in_eff,
  output logic [W-1:0] hi_eff,
  output logic [W-1:0] lo_eff
);
  localparam int unsigned SLOTS = 3;

  function automatic logic [W-1:0] rst_of(input int unsigned idx);
    case (idx)
      0:       rst_of = W'(RST_IN);
      1:       rst_of = '1;
      default: rst_of = '0;
    endcase
  endfunction

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [W-1:0] q;
    logic [W-1:0] d;

    always_comb begin
      d = q;
      if (wr_sel[i]) d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= rst_of(i);
      else        q <= d;
    end
  end

  assign in_q   = g_slot[0].q;
  assign hi_q   = g_slot[1].q;
  assign lo_q   = g_slot[2].q;
  // Forwarded values: what the registers will hold after this edge
  assign in_eff = g_slot[0].d;
  assign hi_eff = g_slot[1].d;
  assign lo_eff = g_slot[2].d;
endmodule

// File: rtl/vcom_clamp.sv
module vcom_clamp #(
  parameter int unsigned W        = 10,
  parameter int unsigned CODE_MAX = 960
) (
  input  logic [W-1:0] in_v,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  output logic [W-1:0] out_v
);
  logic [W-1:0] lim;

  always_comb begin
    lim = in_v;
    if (hi >= lo) begin
      if (in_v > hi)      lim = hi;
      else if (in_v < lo) lim = lo;
    end
  end

  if (CODE_MAX < (2**W) - 1) begin : g_cap
    localparam logic [W-1:0] CAP = W'(CODE_MAX);
    assign out_v = (lim > CAP) ? CAP : lim;
  end else begin : g_nocap
    assign out_v = lim;
  end
endmodule

// File: rtl/vcom_clamp_reg.sv
module vcom_clamp_reg
  import vcom_pkg::*;
#(
  parameter int unsigned W        = CODE_W,
  parameter int unsigned CODE_MAX = 960,
  parameter int unsigned RST_CODE = 'h200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [W-1:0]     wr_data,
  input  logic             upd_en,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [W-1:0]     rd_data,
  output logic [W-1:0]     dac_code,
  output logic [W-1:0]     nvm_data
);
  localparam logic [W-1:0] RST_V = W'(RST_CODE);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  wsel_t        wsel;
  logic [W-1:0] in_q, hi_lim, lo_lim;
  logic [W-1:0] in_eff, hi_eff, lo_eff;
  logic [W-1:0] clamped;

  vcom_wr_decode u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .sel     (wsel)
  );

  vcom_stage1 #(.W(W), .RST_IN(RST_CODE)) u_stage1 (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_sel  ({wsel.lo, wsel.hi, wsel.vcom}),
    .wr_data (wr_data),
    .in_q    (in_q),
    .hi_q    (hi_lim),
    .lo_q    (lo_lim),
    .in_eff  (in_eff),
    .hi_eff  (hi_eff),
    .lo_eff  (lo_eff)
  );

  vcom_clamp #(.W(W), .CODE_MAX(CODE_MAX)) u_clamp (
    .in_v  (in_eff),
    .hi    (hi_eff),
    .lo    (lo_eff),
    .out_v (clamped)
  );

  // Second layer
  logic [W-1:0] out_q, out_d;
  always_comb begin
    out_d = out_q;
    if (upd_en) out_d = clamped;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_q <= RST_V;
    else             out_q <= out_d;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == SEL_VCOM)        rd_data = out_q;
    else if (rd_addr == SEL_LIM_HI) rd_data = hi_lim;
    else if (rd_addr == SEL_LIM_LO) rd_data = lo_lim;
  end

  assign dac_code = out_q;
  assign nvm_data = in_q;
endmodule

// File: rtl/vcom_clamp_chk.sv
module vcom_clamp_chk #(
  parameter int unsigned W        = 10,
  parameter int unsigned CODE_MAX = 960
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         upd_en,
  input logic [W-1:0] dac_code,
  input logic [W-1:0] nvm_data,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  localparam logic [W-1:0] CAP = (CODE_MAX < (2**W) - 1) ? W'(CODE_MAX) : '1;

  // R3
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(dac_code));

  // R10
  dac_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_code <= CAP);

  // R9
  nvm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(nvm_data));

  // R4
  clip_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !wr_en && hi >= lo && nvm_data > hi)
      |=> dac_code == (($past(hi) > CAP) ? CAP : $past(hi)));

  // R5
  clip_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !wr_en && hi >= lo && nvm_data < lo)
      |=> dac_code == (($past(lo) > CAP) ? CAP : $past(lo)));

  // R6
  inverted_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !wr_en && hi < lo)
      |=> dac_code == (($past(nvm_data) > CAP) ? CAP : $past(nvm_data)));
endmodule

bind vcom_clamp_reg vcom_clamp_chk #(.W(W), .CODE_MAX(CODE_MAX)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_en    (wr_en),
  .upd_en   (upd_en),
  .dac_code (dac_code),
  .nvm_data (nvm_data),
  .hi       (hi_lim),
  .lo       (lo_lim)
);

// File: tb/vcom_clamp_reg_tb.sv
module vcom_clamp_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, upd_en;
  logic [5:0] wr_addr, rd_addr;
  logic [9:0] wr_data, rd_data, dac_code, nvm_data;

  always #2 clk = ~clk;

  vcom_clamp_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .upd_en(upd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .dac_code(dac_code), .nvm_data(nvm_data)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  // Shadow of the requested code and bounds
  logic [9:0] m_in = 10'h200, m_hi = 10'h3FF, m_lo = 10'h000;

  int         due_q[$];
  logic [9:0] exp_q[$];
  string      tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [9:0] model(input logic [9:0] v, input logic [9:0] h, input logic [9:0] l);
    logic [9:0] r;
    r = v;
    if (h >= l) begin
      if (v > h) r = h;
      else if (v < l) r = l;
    end
    if (r > 10'd960) r = 10'd960;
    return r;
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic shadow(input logic [5:0] a, input logic [9:0] d);
    if (a == 6'h12) m_in = d;
    else if (a == 6'h1E) m_hi = d;
    else if (a == 6'h1F) m_lo = d;
  endtask

  task automatic do_write(input logic [5:0] a, input logic [9:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    shadow(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Update pulse, optionally with a same-cycle write (R12)
  task automatic do_update(input string tag, input bit with_wr, input logic [5:0] a, input logic [9:0] d);
    @(negedge clk);
    upd_en = 1'b1;
    if (with_wr) begin
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      shadow(a, d);
    end
    due_q.push_back(cyc + 1);
    exp_q.push_back(model(m_in, m_hi, m_lo));
    tag_q.push_back(tag);
    @(negedge clk);
    upd_en = 1'b0; wr_en = 1'b0;
  endtask

  // Monitor: compares dac_code one cycle after each update pulse
  always @(negedge clk) begin
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      check(tag_q[0], dac_code, exp_q[0]);
      void'(due_q.pop_front());
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic read_chk(input string tag, input logic [5:0] a, input logic [9:0] exp);
    rd_addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; upd_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 dac", dac_code, 10'h200);
    check("R1 nvm", nvm_data, 10'h200);
    read_chk("R1 hi", 6'h1E, 10'h3FF);
    read_chk("R1 lo", 6'h1F, 10'h000);
    read_chk("R1 rd code", 6'h12, 10'h200);

    // R2: the write reaches the first layer only
    do_write(6'h12, 10'h150);
    check("R2 nvm after write", nvm_data, 10'h150);
    check("R2 dac held", dac_code, 10'h200);
    repeat (3) @(negedge clk);
    check("R2 dac still held", dac_code, 10'h200);
    do_update("R3 R7 update in range", 0, 6'h0, 10'h0);

    // R10 cap at 960 with the reset bounds
    do_write(6'h12, 10'd1000);
    check("R9 nvm unclamped", nvm_data, 10'd1000);
    do_update("R10 cap 960", 0, 6'h0, 10'h0);
    @(negedge clk);

    // R8: a bound write alone does not move the DAC
    do_write(6'h1E, 10'h300);
    check("R8 dac after bound write", dac_code, 10'd960);
    do_update("R4 R8 above upper", 0, 6'h0, 10'h0);
    @(negedge clk);
    read_chk("R11 rd code", 6'h12, 10'h300);
    read_chk("R11 rd hi", 6'h1E, 10'h300);
    check("R9 nvm keeps raw", nvm_data, 10'd1000);

    // R5 below the lower bound
    do_write(6'h1F, 10'h100);
    do_write(6'h12, 10'h050);
    check("R9 nvm low", nvm_data, 10'h050);
    do_update("R5 below lower", 0, 6'h0, 10'h0);
    @(negedge clk);
    read_chk("R11 rd lo", 6'h1F, 10'h100);

    // R6 inverted bounds: ignored
    do_write(6'h1E, 10'h080);
    do_update("R6 inverted passes raw", 0, 6'h0, 10'h0);
    do_write(6'h12, 10'h3F0);
    do_update("R6 R10 inverted still capped", 0, 6'h0, 10'h0);

    // R12 write and update in the same cycle
    do_write(6'h1E, 10'h300);
    do_update("R12 code written with update", 1, 6'h12, 10'h200);
    do_update("R12 lower written with update", 1, 6'h1F, 10'h250);

    // Equal bounds pin the code (R4)
    do_write(6'h1E, 10'h180);
    do_write(6'h1F, 10'h180);
    do_update("R4 equal bounds", 0, 6'h0, 10'h0);

    // R7 code exactly on a bound
    do_write(6'h1E, 10'h3A0);
    do_write(6'h1F, 10'h010);
    do_write(6'h12, 10'h3A0);
    do_update("R7 code on upper bound", 0, 6'h0, 10'h0);

    // R11 unmapped address
    read_chk("R11 unmapped", 6'h05, 10'h000);
    read_chk("R11 unmapped high", 6'h3F, 10'h000);

    repeat (3) @(negedge clk);
    check("R3 all updates observed", 10'(due_q.size()), 10'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule